// File: doc/BRIEF.md
# Callee-saved register frame pusher

The block builds the extended part of an exception stack frame, the part that holds the callee-saved registers. It runs when an exception interrupts secure background code. A start pulse captures eight register values (r4 to r11), the live stack pointer, the two secure banked stack pointers, the exception return code and a tail-chain flag. From these inputs the block picks the stack pointer to build on and computes a frame pointer ten words below it.

It then issues nine 32-bit writes on a simple request/grant memory port, in ascending address order. The first write is a fixed integrity signature. The second word of the frame is left as a hole and is never written. The eight registers fill the rest of the frame. When the last write has been accepted, the block pulses done and, in that same cycle, tells the surrounding core which stack pointer to overwrite and with which value.

For a normal entry the frame goes on the live stack pointer. When tail-chaining, the frame goes on a secure stack pointer instead. The choice between main and process is made from the mode and stack-select bits of the return code.

Top module: `callee_frame_pusher`

## Requirements
- R1: After reset is released, and until the first start, mem_req_o, done_o and sp_we_o are all low.
- R2: The frame pointer equals the selected stack pointer minus 0x28. This value appears on sp_data_o while done_o is high.
- R3: The first write of every frame stores 0xFEFA125B at the frame pointer.
- R4: Register rN (regs_i bits [32*(N-4)+31 : 32*(N-4)] for N = 4..11) is stored at frame pointer + 4*(N-2), which places r4 at +0x8 and r11 at +0x24.
- R5: Exactly nine writes make up a frame, and address frame pointer + 0x4 is never written.
- R6: With tail_i low the frame is built on sp_act_i, and sp_sel_o is 0 (active pointer).
- R7: With tail_i high, return-code bit 3 (1 = thread) and bit 2 (1 = process stack) choose the pointer. Thread with process selects sp_sec_proc_i and gives sp_sel_o = 2. Every other combination selects sp_sec_main_i and gives sp_sel_o = 1.
- R8: A write is accepted only when mem_req_o and mem_gnt_i are both high at a clock edge. While mem_gnt_i is low, address and data hold.
- R9: done_o and sp_we_o are high for exactly one cycle, the cycle after the last write is accepted.
- R10: A start_i pulse that arrives while a frame is in progress is ignored. It adds no writes and starts no new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame (sampled when idle) |
| tail_i | input | 1 | Entry is a tail-chain |
| ret_code_i | input | 32 | Exception return code; bit 3 mode, bit 2 stack select |
| regs_i | input | 256 | r4..r11 packed, r4 in the low word |
| sp_act_i | input | 32 | Live stack pointer |
| sp_sec_main_i | input | 32 | Secure main stack pointer |
| sp_sec_proc_i | input | 32 | Secure process stack pointer |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | 32 | Write byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Write accepted this cycle |
| done_o | output | 1 | Frame complete pulse |
| sp_we_o | output | 1 | Stack pointer update strobe |
| sp_sel_o | output | 2 | Pointer to update: 0 active, 1 secure main, 2 secure process |
| sp_data_o | output | 32 | New stack pointer value |

## Verification
A start pulse sampled at edge N raises the first request after that edge. Each later write follows the edge at which the previous one was granted. The done and pointer-update outputs appear in the cycle after the final grant. The bench drives the grant 2 ns after each rising edge and samples every output at the falling edge. It records each handshake together with its cycle number and requires the done cycle to be the last handshake cycle plus one. Stall patterns on the grant stretch the frame, so address, data and completion timing are checked under back-pressure as well as at full rate.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  typedef enum logic [1:0] {
    SP_ACTIVE   = 2'd0,
    SP_SEC_MAIN = 2'd1,
    SP_SEC_PROC = 2'd2
  } sp_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_DONE = 2'd2
  } state_e;

  localparam logic [31:0] FRAME_SIG = 32'hFEFA_125B;
  localparam int unsigned RET_MODE_BIT  = 3;
  localparam int unsigned RET_SPSEL_BIT = 2;
endpackage

// File: rtl/cfp_sp_select.sv
module cfp_sp_select
  import cfp_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          tail_i,
  input  logic          thread_i,
  input  logic          proc_i,
  input  logic [AW-1:0] sp_act_i,
  input  logic [AW-1:0] sp_sec_main_i,
  input  logic [AW-1:0] sp_sec_proc_i,
  output sp_sel_e       sel_o,
  output logic [AW-1:0] sp_o
);
  always_comb begin
    if (!tail_i) begin
      sel_o = SP_ACTIVE;
      sp_o  = sp_act_i;
    end else if (thread_i && proc_i) begin
      sel_o = SP_SEC_PROC;
      sp_o  = sp_sec_proc_i;
    end else begin
      // handler mode always runs on the main stack
      sel_o = SP_SEC_MAIN;
      sp_o  = sp_sec_main_i;
    end
  end
endmodule

// File: rtl/cfp_word_gen.sv
module cfp_word_gen #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned NREG  = 8,
  parameter int unsigned IW    = 4,
  parameter logic [DW-1:0] SIG = '0
) (
  input  logic [IW-1:0]      idx_i,
  input  logic [NREG*DW-1:0] regs_i,
  output logic [AW-1:0]      off_o,
  output logic [DW-1:0]      data_o
);
  logic [DW-1:0] reg_words [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_split
    assign reg_words[g] = regs_i[g*DW +: DW];
  end

  always_comb begin
    off_o  = '0;
    data_o = SIG;
    if (idx_i != '0) begin
      // word 1 is the reserved hole, so register k sits at word k+1
      off_o = (AW'(idx_i) + AW'(1)) << 2;
      data_o = '0;
      for (int k = 0; k < NREG; k++) begin
        if (idx_i == IW'(k + 1)) data_o = reg_words[k];
      end
    end
  end
endmodule

// File: rtl/cfp_seq.sv
module cfp_seq
  import cfp_pkg::*;
#(
  parameter int unsigned IW   = 4,
  parameter int unsigned LAST = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          acc_i,
  output logic          idle_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [IW-1:0] idx_o
);
  state_e        st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE: if (launch_i) begin
        st_d  = ST_PUSH;
        idx_d = '0;
      end
      ST_PUSH: if (acc_i) begin
        if (idx_q == IW'(LAST)) st_d = ST_DONE;
        else idx_d = idx_q + IW'(1);
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign idle_o = (st_q == ST_IDLE);
  assign busy_o = (st_q == ST_PUSH);
  assign done_o = (st_q == ST_DONE);
  assign idx_o  = idx_q;
endmodule

// File: rtl/callee_frame_pusher.sv
module callee_frame_pusher
  import cfp_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               tail_i,
  input  logic [31:0]        ret_code_i,
  input  logic [NREG*DW-1:0] regs_i,
  input  logic [AW-1:0]      sp_act_i,
  input  logic [AW-1:0]      sp_sec_main_i,
  input  logic [AW-1:0]      sp_sec_proc_i,
  output logic               mem_req_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic               mem_gnt_i,
  output logic               done_o,
  output logic               sp_we_o,
  output logic [1:0]         sp_sel_o,
  output logic [AW-1:0]      sp_data_o
);
  localparam int unsigned NWORDS      = NREG + 1;
  localparam int unsigned IW          = $clog2(NWORDS);
  localparam logic [AW-1:0] FRAME_LEN = AW'((NREG + 2) * 4);

  logic               idle, busy, done;
  logic [IW-1:0]      idx;
  logic               launch;
  sp_sel_e            sel_c;
  logic [AW-1:0]      sp_c;
  logic [AW-1:0]      off;
  logic [DW-1:0]      wdata;
  logic [AW-1:0]      base_q;
  sp_sel_e            sel_q;
  logic [NREG*DW-1:0] regs_q;

  assign launch = start_i && idle;

  cfp_sp_select #(.AW(AW)) i_sel (
    .tail_i       (tail_i),
    .thread_i     (ret_code_i[RET_MODE_BIT]),
    .proc_i       (ret_code_i[RET_SPSEL_BIT]),
    .sp_act_i     (sp_act_i),
    .sp_sec_main_i(sp_sec_main_i),
    .sp_sec_proc_i(sp_sec_proc_i),
    .sel_o        (sel_c),
    .sp_o         (sp_c)
  );

  cfp_seq #(.IW(IW), .LAST(NWORDS - 1)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .acc_i   (mem_gnt_i),
    .idle_o  (idle),
    .busy_o  (busy),
    .done_o  (done),
    .idx_o   (idx)
  );

  cfp_word_gen #(
    .AW(AW), .DW(DW), .NREG(NREG), .IW(IW), .SIG(DW'(FRAME_SIG))
  ) i_gen (
    .idx_i (idx),
    .regs_i(regs_q),
    .off_o (off),
    .data_o(wdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      sel_q  <= SP_ACTIVE;
      regs_q <= '0;
    end else if (launch) begin
      base_q <= sp_c - FRAME_LEN;
      sel_q  <= sel_c;
      regs_q <= regs_i;
    end
  end

  assign mem_req_o   = busy;
  assign mem_addr_o  = base_q + off;
  assign mem_wdata_o = wdata;
  assign done_o      = done;
  assign sp_we_o     = done;
  assign sp_sel_o    = sel_q;
  assign sp_data_o   = base_q;
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker #(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned NWORDS = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_gnt_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          done_o,
  input logic          sp_we_o
);
  logic [7:0]    acc_cnt;
  logic [AW-1:0] last_addr;
  logic          acc;

  assign acc = mem_req_o && mem_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cnt   <= '0;
      last_addr <= '0;
    end else if (done_o) begin
      acc_cnt <= '0;
    end else if (acc) begin
      acc_cnt   <= acc_cnt + 8'd1;
      last_addr <= mem_addr_o;
    end
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  assert_single_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_acc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(acc));

  assert_we_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> (done_o && !mem_req_o));

  assert_word_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (acc_cnt == 8'(NWORDS)));

  assert_signature_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && acc_cnt == 8'd0) |-> (mem_wdata_o == DW'(32'hFEFA_125B)));

  assert_ascending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && acc_cnt != 8'd0) |-> (mem_addr_o > last_addr));
endmodule

bind callee_frame_pusher cfp_checker #(.AW(AW), .DW(DW), .NWORDS(NREG + 1)) i_cfp_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_gnt_i  (mem_gnt_i),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .done_o     (done_o),
  .sp_we_o    (sp_we_o)
);

// File: tb/test_callee_frame_pusher.sv
`timescale 1ns/1ps
module test_callee_frame_pusher;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         tail_i = 1'b0;
  logic [31:0]  ret_code_i = '0;
  logic [255:0] regs_i = '0;
  logic [31:0]  sp_act_i = '0, sp_sec_main_i = '0, sp_sec_proc_i = '0;
  logic         mem_req_o;
  logic [31:0]  mem_addr_o, mem_wdata_o;
  logic         mem_gnt_i = 1'b0;
  logic         done_o, sp_we_o;
  logic [1:0]   sp_sel_o;
  logic [31:0]  sp_data_o;

  callee_frame_pusher i_callee_frame_pusher (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;
  int stall_mode = 0;
  int gcnt = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // grant driven 2 ns after each rising edge
  always @(posedge clk_i) begin
    #2;
    gcnt = gcnt + 1;
    if (stall_mode == 0) mem_gnt_i = 1'b1;
    else if (stall_mode == 1) mem_gnt_i = (gcnt % 3 == 0);
    else mem_gnt_i = (gcnt % 2 == 0);
  end

  logic [31:0] wa [16];
  logic [31:0] wd [16];
  int nw, ndone, nwe, last_acc, done_cyc, hold_bad;
  logic [1:0]  got_sel;
  logic [31:0] got_sp;
  logic        hold_pend;
  logic [31:0] hold_a, hold_d;

  always @(negedge clk_i) begin
    if (mem_req_o && mem_gnt_i) begin
      if (nw < 16) begin wa[nw] = mem_addr_o; wd[nw] = mem_wdata_o; end
      nw = nw + 1;
      last_acc = cyc;
    end
    if (done_o) begin
      ndone = ndone + 1;
      done_cyc = cyc;
      got_sel = sp_sel_o;
      got_sp = sp_data_o;
    end
    if (sp_we_o) nwe = nwe + 1;
    if (hold_pend && (!mem_req_o || mem_addr_o != hold_a || mem_wdata_o != hold_d))
      hold_bad = hold_bad + 1;
    hold_pend = mem_req_o && !mem_gnt_i;
    hold_a = mem_addr_o;
    hold_d = mem_wdata_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] reg_val(input int k, input logic [31:0] seed);
    return seed ^ (32'h1111_0000 * (k + 1)) ^ 32'(k);
  endfunction

  // one scenario: build a frame and check every result
  task automatic run_frame(input string name, input bit tail, input logic [31:0] ret,
                           input logic [31:0] spa, input logic [31:0] spm, input logic [31:0] spp,
                           input int stall, input bit restart, input logic [31:0] seed);
    logic [31:0] exp_sp, base;
    logic [1:0]  exp_sel;
    int to;
    if (!tail) begin exp_sp = spa; exp_sel = 2'd0; end
    else if (ret[3] && ret[2]) begin exp_sp = spp; exp_sel = 2'd2; end
    else begin exp_sp = spm; exp_sel = 2'd1; end
    base = exp_sp - 32'h28;

    @(negedge clk_i);
    stall_mode = stall;
    nw = 0; ndone = 0; nwe = 0; hold_bad = 0; hold_pend = 1'b0;
    tail_i = tail; ret_code_i = ret;
    sp_act_i = spa; sp_sec_main_i = spm; sp_sec_proc_i = spp;
    for (int k = 0; k < 8; k++) regs_i[32*k +: 32] = reg_val(k, seed);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (restart) begin
      repeat (2) @(negedge clk_i);
      sp_act_i = spa + 32'h400; sp_sec_main_i = spm + 32'h400; sp_sec_proc_i = spp + 32'h400;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    to = 0;
    while (ndone == 0 && to < 300) begin @(negedge clk_i); to++; end
    repeat (4) @(negedge clk_i);

    chk(ndone == 1, {name, " R9 done pulse count"}, 32'(ndone), 32'd1);
    chk(nwe == 1, {name, " R9 sp_we pulse count"}, 32'(nwe), 32'd1);
    chk(done_cyc == last_acc + 1, {name, " R9 done cycle"}, 32'(done_cyc), 32'(last_acc + 1));
    chk(nw == 9, {name, " R5 write count"}, 32'(nw), 32'd9);
    chk(got_sp == base, {name, " R2 new stack pointer"}, got_sp, base);
    chk(got_sel == exp_sel, {name, tail ? " R7 pointer select" : " R6 pointer select"},
        32'(got_sel), 32'(exp_sel));
    if (nw >= 1) begin
      chk(wa[0] == base, {name, " R3 signature address"}, wa[0], base);
      chk(wd[0] == 32'hFEFA_125B, {name, " R3 signature data"}, wd[0], 32'hFEFA_125B);
    end
    for (int i = 0; i < nw && i < 16; i++)
      chk(wa[i] != base + 32'h4, {name, " R5 hole written"}, wa[i], base + 32'h4);
    for (int k = 0; k < 8; k++) begin
      if (nw > k + 1) begin
        chk(wa[k+1] == base + 32'(4 * (k + 2)), {name, " R4 register address"},
            wa[k+1], base + 32'(4 * (k + 2)));
        chk(wd[k+1] == reg_val(k, seed), {name, " R4 register data"}, wd[k+1], reg_val(k, seed));
      end
    end
    chk(hold_bad == 0, {name, " R8 hold under stall"}, 32'(hold_bad), 32'd0);
    chk(mem_req_o == 1'b0, {name, " R10 idle after frame"}, 32'(mem_req_o), 32'd0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk_i);
    chk(mem_req_o == 1'b0, "R1 req after reset", 32'(mem_req_o), 32'd0);
    chk(done_o == 1'b0, "R1 done after reset", 32'(done_o), 32'd0);
    chk(sp_we_o == 1'b0, "R1 sp_we after reset", 32'(sp_we_o), 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    run_frame("plain_full", 1'b0, 32'hFFFF_FFBC, 32'h2000_1000, 32'h3000_0800, 32'h3000_4800, 0, 1'b0, 32'h1234_5678);
    run_frame("plain_stall", 1'b0, 32'hFFFF_FFB0, 32'h2000_2040, 32'h3000_0800, 32'h3000_4800, 1, 1'b0, 32'hCAFE_0001);
    run_frame("tail_thread_proc", 1'b1, 32'hFFFF_FFBC, 32'h2000_1000, 32'h3000_0800, 32'h3000_4800, 0, 1'b0, 32'h0BAD_F00D);
    run_frame("tail_thread_main", 1'b1, 32'hFFFF_FFB8, 32'h2000_1000, 32'h3000_0800, 32'h3000_4800, 2, 1'b0, 32'h5555_AAAA);
    run_frame("tail_handler", 1'b1, 32'hFFFF_FFB0, 32'h2000_1000, 32'h3000_0800, 32'h3000_4800, 1, 1'b0, 32'h0F0F_0F0F);
    run_frame("tail_handler_psel", 1'b1, 32'hFFFF_FFB4, 32'h2000_1000, 32'h3000_0C00, 32'h3000_4800, 0, 1'b0, 32'h7777_1111);
    run_frame("restart_busy", 1'b0, 32'hFFFF_FFBC, 32'h2000_3000, 32'h3000_0800, 32'h3000_4800, 1, 1'b1, 32'h9999_0000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule